// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a synthesizable target-side model of a two-wire serial memory holding 8192 bytes, arranged as 256 rows of 32 bytes. It runs on a fast system clock and oversamples the bus clock and data lines. It pulls the open-drain data line low through an output enable. A host addresses it with a device byte. The upper nibble of that byte is fixed, the next three bits must equal the strap pins, and the last bit selects read or write. A write carries a two-byte word address. A read can start at the internal address pointer, or at a pointer loaded just before by a write with no data bytes.

Write data goes into a one-row staging buffer. It reaches the array only when a stop ends the transfer. A timed busy period then follows, and the target answers no device byte until it ends, so a host can poll for completion. A write-protect input blocks updates to the top quarter of the array. Reads stream out bytes for as long as the host acknowledges and wrap across the whole array. Writes wrap inside the current row.

The bus pins are bit-level control signals, so no valid/ready stream appears at this boundary. The host paces every transfer through the clock line, and the target applies no back-pressure beyond leaving a byte without acknowledge.

Top module: `eeprom2w_target`

## Requirements
- R1: After reset, and after any stop, the target releases the data line (`sda_oe_o` = 0).
- R2: The target acknowledges a device byte only when its bits 7..4 are 1010 and bits 3..1 equal `strap_i`. Bit 0 = 1 means read and 0 means write. On a mismatch the data line stays released for the acknowledge bit.
- R3: A write carries a high then a low word-address byte. Only the lower 13 bits of these 16 bits count, so bits 15..13 have no effect.
- R4: Data bytes from a write reach the array only when a stop follows them. Only the bytes that were sent change.
- R5: During a write, only address bits 4..0 advance after each data byte, wrapping inside the 32-byte row. A 33rd and later byte overwrites earlier bytes of that row.
- R6: For `BUSY_CYCLES` system clocks after a committing stop, every device byte goes unacknowledged. After that, device bytes are acknowledged again.
- R7: While `wp_i` = 1 at the stop, a write to addresses 0x1800..0x1FFF leaves the array unchanged. Writes below 0x1800 are unaffected. While `wp_i` = 0, all addresses are writable.
- R8: A read with no word address returns the byte at one past the last byte read or written.
- R9: A sequential read advances over the whole array after each host acknowledge and wraps from 0x1FFF to 0x0000. A host non-acknowledge ends it.
- R10: Read bytes go out MSB first. The enable changes only while the clock line is low, except at start and stop. The line is released during the host's acknowledge bit.
- R11: A repeated start aborts the transfer in progress, commits no staged data, and returns to device-byte reception. A random read uses this to follow an address-only write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired value) |
| strap_i | input | 3 | Device select strap pins |
| wp_i | input | 1 | Write protect for the top quarter of the array |
| sda_oe_o | output | 1 | 1 pulls the data line low |

## Verification
The assertions take several things for granted. Each high and low phase of the clock line lasts well beyond the synchronizer depth. The host moves the data line only in the middle of clock-low phases, apart from start and stop. `wp_i` holds steady from a stop through the busy period. The bench drives the bus with a quarter period of ten system clocks and changes the data line a full quarter after each clock fall. It sets the write-protect level only while the bus is idle and no busy period is running, so the checks on enable timing and protected writes see only legal bus traffic.

// File: rtl/e2w_pkg.sv
package e2w_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_TX, ST_WAIT} bus_st_e;
  typedef enum logic [1:0] {RX_DEV, RX_AHI, RX_ALO, RX_DATA} rx_kind_e;
  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/e2w_sync.sv
module e2w_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic wp_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_p, sda_p, wp_p;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      wp_p  <= '0;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      wp_p  <= {wp_p[STAGES-2:0], wp_i};
      scl_q <= scl_p[STAGES-1];
      sda_q <= sda_p[STAGES-1];
    end
  end

  assign scl_lvl   = scl_p[STAGES-1];
  assign sda_lvl   = sda_p[STAGES-1];
  assign wp_lvl    = wp_p[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/e2w_pagebuf.sv
module e2w_pagebuf #(
  parameter int PAGE_W      = 5,
  parameter int ROW_W       = 8,
  parameter int BUSY_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_idx,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [7:0]        wr_data,
  input  logic              clear,
  input  logic              commit,
  input  logic              wp_lvl,
  output logic              busy,
  output logic              pending,
  output logic              mem_we,
  output logic [PAGE_W+ROW_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int CNT_W      = $clog2(BUSY_CYCLES + 1);

  logic [7:0]            stage_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid_q;
  logic [ROW_W-1:0]      row_q;
  logic                  prot_q;
  logic                  walk_q;
  logic [PAGE_W-1:0]     walk_idx;
  logic [CNT_W-1:0]      timer_q;

  always_ff @(posedge clk) begin
    if (wr_en) stage_q[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= '0;
      row_q    <= '0;
      prot_q   <= 1'b0;
      walk_q   <= 1'b0;
      walk_idx <= '0;
      timer_q  <= '0;
    end else begin
      if (clear) begin
        valid_q <= '0;
      end else if (wr_en) begin
        valid_q[wr_idx] <= 1'b1;
        row_q           <= wr_row;
      end
      if (commit) begin
        walk_q   <= 1'b1;
        walk_idx <= '0;
        timer_q  <= CNT_W'(BUSY_CYCLES);
        prot_q   <= wp_lvl & (&row_q[ROW_W-1 -: 2]);
      end else begin
        if (timer_q != '0) timer_q <= timer_q - CNT_W'(1);
        if (walk_q) begin
          valid_q[walk_idx] <= 1'b0;
          walk_idx          <= walk_idx + PAGE_W'(1);
          if (walk_idx == PAGE_W'(PAGE_BYTES - 1)) walk_q <= 1'b0;
        end
      end
    end
  end

  assign busy      = walk_q | (timer_q != '0);
  assign pending   = |valid_q;
  assign mem_we    = walk_q & valid_q[walk_idx] & ~prot_q;
  assign mem_waddr = {row_q, walk_idx};
  assign mem_wdata = stage_q[walk_idx];
endmodule

// File: rtl/e2w_mem.sv
module e2w_mem #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/e2w_proto.sv
module e2w_proto
  import e2w_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [2:0]        strap,
  input  logic              busy,
  input  logic              pending,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] ptr,
  output logic              buf_we,
  output logic [PAGE_W-1:0] buf_idx,
  output logic [ADDR_W-PAGE_W-1:0] buf_row,
  output logic [7:0]        buf_data,
  output logic              buf_clear,
  output logic              commit,
  output logic              sda_oe
);
  localparam int HI_W = ADDR_W - 8;

  bus_st_e     st;
  rx_kind_e    kind;
  logic [3:0]  bitcnt;
  logic [7:0]  shreg;
  logic        rw;
  logic        hack;
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      kind      <= RX_DEV;
      bitcnt    <= '0;
      shreg     <= '0;
      rw        <= 1'b0;
      hack      <= 1'b1;
      hi_q      <= '0;
      ptr       <= '0;
      buf_we    <= 1'b0;
      buf_idx   <= '0;
      buf_row   <= '0;
      buf_data  <= '0;
      buf_clear <= 1'b0;
      commit    <= 1'b0;
      sda_oe    <= 1'b0;
    end else begin
      buf_we    <= 1'b0;
      buf_clear <= 1'b0;
      commit    <= 1'b0;
      if (start_det) begin
        st     <= ST_RX;
        kind   <= RX_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
        if (!busy) buf_clear <= 1'b1;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
        if (pending && !busy) commit <= 1'b1;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise) begin
              if (bitcnt < 4'd8) shreg <= {shreg[6:0], sda_lvl};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              sda_oe <= 1'b1;
              case (kind)
                RX_DEV: begin
                  if (shreg[7:4] == DEV_TYPE && shreg[3:1] == strap && !busy) begin
                    rw <= shreg[0];
                  end else begin
                    sda_oe <= 1'b0;
                    st     <= ST_WAIT;
                  end
                end
                RX_AHI: hi_q <= shreg[HI_W-1:0];
                RX_ALO: ptr  <= {hi_q, shreg};
                RX_DATA: begin
                  buf_we   <= 1'b1;
                  buf_idx  <= ptr[PAGE_W-1:0];
                  buf_row  <= ptr[ADDR_W-1:PAGE_W];
                  buf_data <= shreg;
                  ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + PAGE_W'(1);
                end
                default: ;
              endcase
            end else if (scl_fall && bitcnt == 4'd9) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              case (kind)
                RX_DEV: begin
                  if (rw) begin
                    st     <= ST_TX;
                    shreg  <= rd_data;
                    sda_oe <= ~rd_data[7];
                  end else begin
                    kind <= RX_AHI;
                  end
                end
                RX_AHI:  kind <= RX_ALO;
                RX_ALO:  kind <= RX_DATA;
                default: ;
              endcase
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              if (bitcnt == 4'd8) hack <= sda_lvl;
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
              end else if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                ptr    <= ptr + ADDR_W'(1);
              end else if (bitcnt == 4'd9) begin
                bitcnt <= '0;
                if (!hack) begin
                  shreg  <= rd_data;
                  sda_oe <= ~rd_data[7];
                end else begin
                  st <= ST_WAIT;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eeprom2w_target.sv
module eeprom2w_target #(
  parameter int ADDR_W      = 13,
  parameter int PAGE_W      = 5,
  parameter int BUSY_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  localparam int ROW_W = ADDR_W - PAGE_W;

  logic scl_lvl, sda_lvl, wp_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic busy, pending, buf_we, buf_clear, commit, mem_we;
  logic [PAGE_W-1:0] buf_idx;
  logic [ROW_W-1:0]  buf_row;
  logic [7:0]        buf_data, rd_data, mem_wdata;
  logic [ADDR_W-1:0] ptr, mem_waddr;

  e2w_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .wp_i(wp_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .wp_lvl(wp_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  e2w_proto #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_proto (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .strap(strap_i),
    .busy(busy), .pending(pending), .rd_data(rd_data), .ptr(ptr),
    .buf_we(buf_we), .buf_idx(buf_idx), .buf_row(buf_row), .buf_data(buf_data),
    .buf_clear(buf_clear), .commit(commit), .sda_oe(sda_oe_o)
  );

  e2w_pagebuf #(.PAGE_W(PAGE_W), .ROW_W(ROW_W), .BUSY_CYCLES(BUSY_CYCLES)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(buf_we), .wr_idx(buf_idx), .wr_row(buf_row),
    .wr_data(buf_data), .clear(buf_clear), .commit(commit), .wp_lvl(wp_lvl),
    .busy(busy), .pending(pending), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata)
  );

  e2w_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(ptr), .rdata(rd_data)
  );
endmodule

// File: rtl/e2w_checks.sv
module e2w_checks #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_lvl,
  input logic              start_det,
  input logic              stop_det,
  input logic              sda_oe_o,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_waddr,
  input logic              wp_lvl
);
  a_r10_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_oe_o != $past(sda_oe_o)) && !$past(start_det) && !$past(stop_det)) |-> !scl_lvl);

  a_r6_silent_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe_o);

  a_r4_array_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  a_r4_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det, 2));

  a_r7_protected_quarter: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && (&mem_waddr[ADDR_W-1 -: 2])) |-> !wp_lvl);

  a_r1_release_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe_o);
endmodule

bind eeprom2w_target e2w_checks #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .start_det(start_det),
  .stop_det(stop_det), .sda_oe_o(sda_oe_o), .busy(busy), .mem_we(mem_we),
  .mem_waddr(mem_waddr), .wp_lvl(wp_lvl)
);

// File: tb/tb_eeprom2w_target.sv
module tb_eeprom2w_target;
  localparam int Q = 10;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_host = 1'b1, wp = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_oe, sda_line;
  int checks = 0, errors = 0;
  logic [7:0] exp_q[$], got_q[$];
  string tag_q[$];
  bit released_ok;

  assign sda_line = sda_host & ~sda_oe;
  always #4 clk = ~clk;

  eeprom2w_target #(.BUSY_CYCLES(400)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_i(strap), .wp_i(wp), .sda_oe_o(sda_oe)
  );

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (got_q.size() > 0) begin
      logic [7:0] g, e;
      string t;
      g = got_q.pop_front();
      if (exp_q.size() == 0) check(1'b0, "SB-extra", g, 0);
      else begin
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(g === e, t, g, e);
      end
    end
  end

  task automatic expect_byte(input logic [7:0] b, input string t);
    exp_q.push_back(b); tag_q.push_back(t);
  endtask

  task automatic bus_start();
    sda_host = 1'b1; wt(Q); scl = 1'b1; wt(Q); sda_host = 1'b0; wt(Q); scl = 1'b0; wt(Q);
  endtask
  task automatic bus_stop();
    sda_host = 1'b0; wt(Q); scl = 1'b1; wt(Q); sda_host = 1'b1; wt(2*Q);
  endtask
  task automatic wbit(input bit b);
    sda_host = b; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q);
  endtask
  task automatic rbit(output bit b);
    sda_host = 1'b1; wt(Q); scl = 1'b1; wt(Q); b = sda_line; wt(Q); scl = 1'b0; wt(Q);
  endtask
  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    rbit(ack);
  endtask
  task automatic recv_byte(input bit hack);
    logic [7:0] b;
    bit x;
    for (int i = 7; i >= 0; i--) begin rbit(x); b[i] = x; end
    sda_host = hack; wt(Q); scl = 1'b1; wt(Q);
    if (sda_oe) released_ok = 1'b0;
    wt(Q); scl = 1'b0; wt(Q);
    got_q.push_back(b);
  endtask

  function automatic logic [7:0] devb(input bit rd);
    return {4'b1010, strap, rd};
  endfunction

  task automatic write_tx(input logic [15:0] a, input logic [7:0] d[$], output bit ok);
    bit ack;
    ok = 1'b1;
    bus_start();
    send_byte(devb(1'b0), ack); ok &= !ack;
    send_byte(a[15:8], ack);    ok &= !ack;
    send_byte(a[7:0], ack);     ok &= !ack;
    foreach (d[i]) begin send_byte(d[i], ack); ok &= !ack; end
    bus_stop();
  endtask

  task automatic rand_read(input logic [15:0] a, input int n, output bit ok);
    bit ack;
    ok = 1'b1;
    bus_start();
    send_byte(devb(1'b0), ack); ok &= !ack;
    send_byte(a[15:8], ack);    ok &= !ack;
    send_byte(a[7:0], ack);     ok &= !ack;
    bus_start();
    send_byte(devb(1'b1), ack); ok &= !ack;
    for (int i = 0; i < n; i++) recv_byte(i == n - 1);
    bus_stop();
  endtask

  task automatic wait_done(); wt(450); endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit ok, ack;
    logic [7:0] d[$];
    wt(5); rst_n = 1'b1; wt(5);
    check(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);

    // R2: mismatching straps and prefix
    bus_start(); send_byte({4'b1010, ~strap, 1'b0}, ack); bus_stop();
    check(ack == 1'b1, "R2 strap mismatch nack", ack, 1);
    bus_start(); send_byte({4'b1011, strap, 1'b0}, ack); bus_stop();
    check(ack == 1'b1, "R2 prefix mismatch nack", ack, 1);

    // R4: byte write then random read
    d = '{8'h5A}; write_tx(16'h0123, d, ok);
    check(ok, "R2 match acks", ok, 1);
    // R6: polling during busy
    bus_start(); send_byte(devb(1'b0), ack); bus_stop();
    check(ack == 1'b1, "R6 busy nack", ack, 1);
    wait_done();
    bus_start(); send_byte(devb(1'b0), ack); bus_stop();
    check(ack == 1'b0, "R6 ack after busy", ack, 0);
    expect_byte(8'h5A, "R4 byte write");
    rand_read(16'h0123, 1, ok);
    check(sda_oe == 1'b0, "R1 release after stop", sda_oe, 0);

    // R4/R8: partial page, then current address read
    d = '{8'hA0, 8'hA1, 8'hA2, 8'hA3}; write_tx(16'h0040, d, ok); wait_done();
    released_ok = 1'b1;
    expect_byte(8'hA0, "R4 page"); expect_byte(8'hA1, "R4 page"); expect_byte(8'hA2, "R4 page");
    rand_read(16'h0040, 3, ok);
    check(released_ok, "R10 release in host ack", released_ok, 1);
    expect_byte(8'hA3, "R8 current address");
    bus_start(); send_byte(devb(1'b1), ack); recv_byte(1'b1); bus_stop();
    check(ack == 1'b0, "R8 read dev ack", ack, 0);

    // R5: wrap inside row
    d = '{8'hB0, 8'hB1, 8'hB2, 8'hB3}; write_tx(16'h009E, d, ok); wait_done();
    expect_byte(8'hB2, "R5 wrap"); expect_byte(8'hB3, "R5 wrap");
    rand_read(16'h0080, 2, ok);
    expect_byte(8'hB0, "R5 wrap"); expect_byte(8'hB1, "R5 wrap");
    rand_read(16'h009E, 2, ok);
    d = {};
    for (int i = 0; i < 34; i++) d.push_back(8'hC0 + 8'(i));
    write_tx(16'h00A0, d, ok); wait_done();
    expect_byte(8'hE0, "R5 overwrite"); expect_byte(8'hE1, "R5 overwrite");
    expect_byte(8'hC2, "R5 overwrite");
    rand_read(16'h00A0, 3, ok);

    // R3: upper word-address bits ignored
    d = '{8'h77}; write_tx(16'hE310, d, ok); wait_done();
    expect_byte(8'h77, "R3 upper bits ignored");
    rand_read(16'h0310, 1, ok);

    // R7: write protect
    d = '{8'h33}; write_tx(16'h1850, d, ok); wait_done();
    wp = 1'b1; wt(10);
    d = '{8'h44}; write_tx(16'h1850, d, ok); wait_done();
    d = '{8'h66}; write_tx(16'h17F0, d, ok); wait_done();
    wp = 1'b0; wt(10);
    expect_byte(8'h33, "R7 protected kept");
    rand_read(16'h1850, 1, ok);
    expect_byte(8'h66, "R7 lower writable");
    rand_read(16'h17F0, 1, ok);

    // R9: sequential wrap across array
    d = '{8'h91, 8'h92}; write_tx(16'h1FFE, d, ok); wait_done();
    d = '{8'h93}; write_tx(16'h0000, d, ok); wait_done();
    expect_byte(8'h91, "R9 seq"); expect_byte(8'h92, "R9 seq"); expect_byte(8'h93, "R9 seq wrap");
    rand_read(16'h1FFE, 3, ok);

    // R11: repeated start aborts staged data
    bus_start();
    send_byte(devb(1'b0), ack); send_byte(8'h03, ack); send_byte(8'h10, ack);
    send_byte(8'hAA, ack);
    bus_start(); send_byte(devb(1'b0), ack);
    bus_stop();
    check(ack == 1'b0, "R11 dev ack after restart", ack, 0);
    wait_done();
    expect_byte(8'h77, "R11 no partial commit");
    rand_read(16'h0310, 1, ok);

    wt(50);
    check(exp_q.size() == 0, "SB drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule